// File: doc/BRIEF.md
# Inclusive L1 Presence Directory with Coherence Return Packets

This block sits beside a shared second-level cache and tracks, for every line slot it covers, which cores hold that line in their level-1 instruction cache and which hold it in their level-1 data cache. It has two input sources. The first is a request carrying a core number, a line index and an operation: an instruction fill, a data fill or a store. The second is an eviction notice carrying a line index. Fills only set presence. Stores and evictions turn into a series of return packets on an output channel with a valid/ready handshake. Each packet names one target core.

A store always acknowledges the core that issued it. If that core has the line in its data cache, the acknowledgement tells it to update that copy. Every other core that holds the line gets an invalidate, and its presence is dropped. An eviction sends an eviction-invalidate to every holder and clears the slot, so level-1 contents stay a subset of the shared cache. When one event needs several packets, they leave in ascending core order, one per accepted handshake. The input is not ready again until the last packet has gone. The directory is stored in one RAM-style array. After reset it is swept to zero before the first request is taken.

Top module: `l1_dir_ctrl`

## Requirements
- R1: After reset the block sweeps every slot to empty. During the sweep `in_ready` and `pkt_valid` are low. Afterwards `in_ready` is high and no core is recorded as a holder.
- R2: `req_op` 0 (instruction fill) sets the requester's instruction-cache presence for `req_idx`, and `req_op` 1 (data fill) sets its data-cache presence. A fill produces no packet.
- R3: Every store (`req_op` 2) produces exactly one acknowledgement packet addressed to `req_core`, with `pkt_l1i` and `pkt_l1d` low.
- R4: The acknowledgement has `pkt_type` 1 (acknowledge-and-update) when the requester held the line in its data cache, and `pkt_type` 0 (plain acknowledge) otherwise.
- R5: On a store, each other core holding the line gets `pkt_type` 2 (invalidate). In that packet `pkt_l1i`/`pkt_l1d` mark which of its caches held the line. All of its presence for the line is then cleared, so a repeated store sends only the acknowledgement.
- R6: A store leaves the requester's own presence bits unchanged.
- R7: An eviction sends `pkt_type` 3 (eviction-invalidate) to every holder, with `pkt_l1i`/`pkt_l1d` marking the caches that held the line, and then clears the slot.
- R8: The packets of one event leave in strictly ascending core order. While `pkt_ready` stays high they go on consecutive cycles.
- R9: `in_ready` stays low from the accepting edge until the last packet of the event has been handed over.
- R10: When an eviction and a request are accepted in the same cycle, the eviction is applied and its packets are sent first. The request is then handled against the updated directory.
- R11: While `pkt_valid` is high and `pkt_ready` is low, all packet fields hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_ready | output | 1 | Block idle; eviction and request are both accepted this cycle |
| evict_valid | input | 1 | Eviction notice present |
| evict_idx | input | $clog2(LINES) | Line slot being evicted |
| req_valid | input | 1 | Request present |
| req_core | input | $clog2(NUM_CORES) | Requesting core |
| req_op | input | 2 | 0 instruction fill, 1 data fill, 2 store |
| req_idx | input | $clog2(LINES) | Line slot of the request |
| pkt_valid | output | 1 | Return packet present |
| pkt_ready | input | 1 | Receiver takes the packet |
| pkt_core | output | $clog2(NUM_CORES) | Destination core |
| pkt_type | output | 2 | 0 ack, 1 ack-and-update, 2 invalidate, 3 eviction-invalidate |
| pkt_l1i | output | 1 | Target's instruction-cache copy affected |
| pkt_l1d | output | 1 | Target's data-cache copy affected |
| pkt_idx | output | $clog2(LINES) | Line slot the packet refers to |

## Verification
An eviction notice and a store or fill can arrive in the same cycle. They can target the same slot or different slots. The bench drives both valids together at one edge, both in directed cases and in a random phase confined to a few slots so that collisions are frequent. The reference model applies the eviction before the request. The result is judged by the exact packet order on the output and by what later stores and evictions reveal about the surviving presence bits, for example a fill that lands after its own slot's eviction and must survive it.

// File: rtl/l1dir_pkg.sv
package l1dir_pkg;
  typedef enum logic [1:0] {
    PK_ACK     = 2'd0,
    PK_ACK_UPD = 2'd1,
    PK_INVAL   = 2'd2,
    PK_EVICT   = 2'd3
  } pkt_kind_e;

  typedef enum logic [2:0] {
    S_INIT, S_IDLE, S_RD, S_SETUP, S_EMIT
  } dir_state_e;
endpackage

// File: rtl/l1dir_store.sv
module l1dir_store #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/l1dir_pick.sv
module l1dir_pick #(
  parameter int N = 4,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  mask,
  output logic [IW-1:0] first,
  output logic          any
);
  always_comb begin
    first = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (mask[k]) first = IW'(k);
    end
    any = |mask;
  end
endmodule

// File: rtl/l1_dir_ctrl.sv
module l1_dir_ctrl
  import l1dir_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int LINES     = 16,
  localparam int CW = $clog2(NUM_CORES),
  localparam int IW = $clog2(LINES),
  localparam int WW = 2 * NUM_CORES
) (
  input  logic          clk,
  input  logic          rst,
  output logic          in_ready,
  input  logic          evict_valid,
  input  logic [IW-1:0] evict_idx,
  input  logic          req_valid,
  input  logic [CW-1:0] req_core,
  input  logic [1:0]    req_op,
  input  logic [IW-1:0] req_idx,
  output logic          pkt_valid,
  input  logic          pkt_ready,
  output logic [CW-1:0] pkt_core,
  output logic [1:0]    pkt_type,
  output logic          pkt_l1i,
  output logic          pkt_l1d,
  output logic [IW-1:0] pkt_idx
);
  dir_state_e state;
  logic [IW-1:0] clr_cnt;
  logic          ev_pend, st_pend;
  logic [IW-1:0] ev_idx, st_idx, cur_idx;
  logic [CW-1:0] st_core;
  logic [1:0]    st_op;
  logic [WW-1:0] held, rd_word, src_word, new_word, wdata;
  logic [NUM_CORES-1:0] pend, setup_mask, rem, scan, req_bit, src_d, src_i;
  logic [NUM_CORES-1:0] rd_d, rd_i;
  logic [CW-1:0] nxt_core;
  logic          nxt_any, we;
  logic [IW-1:0] waddr;
  logic [1:0]    nxt_type;
  logic          nxt_i, nxt_d;

  assign in_ready = (state == S_IDLE);
  assign cur_idx  = ev_pend ? ev_idx : st_idx;
  assign req_bit  = NUM_CORES'(1) << st_core;
  assign rd_d     = rd_word[NUM_CORES-1:0];
  assign rd_i     = rd_word[WW-1:NUM_CORES];

  // Directory update and packet set for the event at the head of the pipe.
  always_comb begin
    if (ev_pend) begin
      setup_mask = rd_d | rd_i;
      new_word   = '0;
    end else if (st_op[1]) begin
      setup_mask = rd_d | rd_i | req_bit;
      new_word   = {rd_i & req_bit, rd_d & req_bit};
    end else begin
      setup_mask = '0;
      new_word   = st_op[0] ? {rd_i, rd_d | req_bit} : {rd_i | req_bit, rd_d};
    end
  end

  assign we    = (state == S_INIT) || (state == S_SETUP);
  assign waddr = (state == S_INIT) ? clr_cnt : cur_idx;
  assign wdata = (state == S_INIT) ? '0 : new_word;

  l1dir_store #(.WIDTH(WW), .DEPTH(LINES)) u_store (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(cur_idx), .rdata(rd_word)
  );

  assign src_word = (state == S_SETUP) ? rd_word : held;
  assign src_d    = src_word[NUM_CORES-1:0];
  assign src_i    = src_word[WW-1:NUM_CORES];
  assign rem      = pend & ~(NUM_CORES'(1) << pkt_core);
  assign scan     = (state == S_SETUP) ? setup_mask : rem;

  l1dir_pick #(.N(NUM_CORES)) u_pick (.mask(scan), .first(nxt_core), .any(nxt_any));

  always_comb begin
    nxt_i = src_i[nxt_core];
    nxt_d = src_d[nxt_core];
    if (ev_pend) begin
      nxt_type = PK_EVICT;
    end else if (nxt_core == st_core) begin
      nxt_type = src_d[nxt_core] ? PK_ACK_UPD : PK_ACK;
      nxt_i    = 1'b0;
      nxt_d    = 1'b0;
    end else begin
      nxt_type = PK_INVAL;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_INIT;
      clr_cnt   <= '0;
      ev_pend   <= 1'b0;
      st_pend   <= 1'b0;
      ev_idx    <= '0;
      st_idx    <= '0;
      st_core   <= '0;
      st_op     <= '0;
      held      <= '0;
      pend      <= '0;
      pkt_valid <= 1'b0;
      pkt_core  <= '0;
      pkt_type  <= '0;
      pkt_l1i   <= 1'b0;
      pkt_l1d   <= 1'b0;
      pkt_idx   <= '0;
    end else begin
      case (state)
        S_INIT: begin
          clr_cnt <= clr_cnt + 1'b1;
          if (clr_cnt == IW'(LINES - 1)) state <= S_IDLE;
        end
        S_IDLE: begin
          if (evict_valid || req_valid) begin
            ev_pend <= evict_valid;
            ev_idx  <= evict_idx;
            st_pend <= req_valid;
            st_core <= req_core;
            st_op   <= req_op;
            st_idx  <= req_idx;
            state   <= S_RD;
          end
        end
        S_RD: state <= S_SETUP;
        S_SETUP, S_EMIT: begin
          if (state == S_SETUP) held <= rd_word;
          if (state == S_SETUP || pkt_ready) begin
            if (nxt_any) begin
              pend      <= scan;
              pkt_valid <= 1'b1;
              pkt_core  <= nxt_core;
              pkt_type  <= nxt_type;
              pkt_l1i   <= nxt_i;
              pkt_l1d   <= nxt_d;
              pkt_idx   <= cur_idx;
              state     <= S_EMIT;
            end else begin
              pkt_valid <= 1'b0;
              pend      <= '0;
              if (ev_pend) begin
                ev_pend <= 1'b0;
                state   <= st_pend ? S_RD : S_IDLE;
              end else begin
                st_pend <= 1'b0;
                state   <= S_IDLE;
              end
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/l1_dir_ctrl_chk.sv
module l1_dir_ctrl_chk
  import l1dir_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int LINES     = 16,
  localparam int CW = $clog2(NUM_CORES),
  localparam int IW = $clog2(LINES)
) (
  input logic          clk,
  input logic          rst,
  input logic          in_ready,
  input logic          pkt_valid,
  input logic          pkt_ready,
  input logic [CW-1:0] pkt_core,
  input logic [1:0]    pkt_type,
  input logic          pkt_l1i,
  input logic          pkt_l1d,
  input logic [IW-1:0] pkt_idx
);
  // R11: a stalled packet keeps every field
  assert_pkt_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid && !pkt_ready) |=> (pkt_valid && $stable(pkt_core) && $stable(pkt_type)
      && $stable(pkt_l1i) && $stable(pkt_l1d) && $stable(pkt_idx)));

  // R9: no new input taken while packets are outstanding
  assert_busy_R9: assert property (@(posedge clk) disable iff (rst)
    pkt_valid |-> !in_ready);

  // R8: a packet that directly follows a handshake goes to a higher core
  assert_ascend_R8: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid && pkt_ready) |=> (!pkt_valid || (pkt_core > $past(pkt_core))));

  // R3: acknowledgements carry no invalidation flags
  assert_ack_flags_R3: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid && (pkt_type == PK_ACK || pkt_type == PK_ACK_UPD)) |-> (!pkt_l1i && !pkt_l1d));

  // R5 / R7: an invalidation always names at least one level-1 copy
  assert_inval_flags_R5: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid && (pkt_type == PK_INVAL || pkt_type == PK_EVICT)) |-> (pkt_l1i || pkt_l1d));
endmodule

bind l1_dir_ctrl l1_dir_ctrl_chk #(.NUM_CORES(NUM_CORES), .LINES(LINES)) u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .pkt_valid(pkt_valid),
  .pkt_ready(pkt_ready), .pkt_core(pkt_core), .pkt_type(pkt_type),
  .pkt_l1i(pkt_l1i), .pkt_l1d(pkt_l1d), .pkt_idx(pkt_idx)
);

// File: tb/tb_l1_dir_ctrl.sv
module tb_l1_dir_ctrl;
  localparam int N  = 4;
  localparam int L  = 16;
  localparam int CW = 2;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_ready, evict_valid, req_valid, pkt_valid, pkt_ready, pkt_l1i, pkt_l1d;
  logic [IW-1:0] evict_idx, req_idx, pkt_idx;
  logic [CW-1:0] req_core, pkt_core;
  logic [1:0] req_op, pkt_type;

  always #10 clk = ~clk;

  l1_dir_ctrl #(.NUM_CORES(N), .LINES(L)) dut (
    .clk(clk), .rst(rst), .in_ready(in_ready),
    .evict_valid(evict_valid), .evict_idx(evict_idx),
    .req_valid(req_valid), .req_core(req_core), .req_op(req_op), .req_idx(req_idx),
    .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_core(pkt_core),
    .pkt_type(pkt_type), .pkt_l1i(pkt_l1i), .pkt_l1d(pkt_l1d), .pkt_idx(pkt_idx)
  );

  typedef struct {
    int core; int kind; bit li; bit ld; int idx; int grp; string tag;
  } exp_t;

  exp_t q[$];
  bit pi [N][L];
  bit pd [N][L];
  int grp_n = 0;
  string tag_ovr = "";
  int checks = 0;
  int fails = 0;
  bit stall = 1'b0;
  bit was_stall = 1'b0;
  bit expect_cont = 1'b0;
  bit running = 1'b0;
  bit finished = 1'b0;

  function automatic string pick_tag(string dflt);
    return (tag_ovr == "") ? dflt : tag_ovr;
  endfunction

  function automatic void model_evict(int idx);
    exp_t e;
    grp_n++;
    for (int c = 0; c < N; c++) begin
      if (pi[c][idx] || pd[c][idx]) begin
        e = '{c, 3, pi[c][idx], pd[c][idx], idx, grp_n, pick_tag("R7")};
        q.push_back(e);
      end
      pi[c][idx] = 1'b0;
      pd[c][idx] = 1'b0;
    end
  endfunction

  function automatic void model_req(int core, int op, int idx);
    exp_t e;
    if (op == 2) begin
      grp_n++;
      for (int c = 0; c < N; c++) begin
        if (c == core) begin
          e = '{c, pd[c][idx] ? 1 : 0, 1'b0, 1'b0, idx, grp_n,
                pick_tag(pd[c][idx] ? "R4" : "R3")};
          q.push_back(e);
        end else if (pi[c][idx] || pd[c][idx]) begin
          e = '{c, 2, pi[c][idx], pd[c][idx], idx, grp_n, pick_tag("R5")};
          q.push_back(e);
          pi[c][idx] = 1'b0;
          pd[c][idx] = 1'b0;
        end
      end
    end else if (op == 1) begin
      pd[core][idx] = 1'b1;
    end else begin
      pi[core][idx] = 1'b1;
    end
  endfunction

  task automatic issue(bit ev, int eidx, bit rq, int core, int op, int ridx);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    evict_valid = ev;
    evict_idx   = IW'(eidx);
    req_valid   = rq;
    req_core    = CW'(core);
    req_op      = 2'(op);
    req_idx     = IW'(ridx);
    @(negedge clk);
    if (ev) model_evict(eidx);
    if (rq) model_req(core, op, ridx);
    evict_valid = 1'b0;
    req_valid   = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    while ((q.size() != 0 || !in_ready) && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  // Reference comparison on every falling edge
  always @(negedge clk) begin
    bit nr;
    int g;
    if (!rst && running) begin
      if (q.size() > 0) begin
        checks++;
        if (in_ready) begin
          fails++;
          $display("FAIL R9: in_ready=%0b expected 0 with %0d packets pending", in_ready, q.size());
        end
      end
      if (expect_cont) begin
        checks++;
        if (!pkt_valid) begin
          fails++;
          $display("FAIL R8: pkt_valid=%0b expected 1 on back-to-back packet", pkt_valid);
        end
      end
      nr = stall ? (($urandom % 3) != 0) : 1'b1;
      expect_cont = 1'b0;
      if (pkt_valid) begin
        checks++;
        if (q.size() == 0) begin
          fails++;
          $display("FAIL R2: unexpected packet core=%0d type=%0d, expected none", pkt_core, pkt_type);
        end else begin
          if (pkt_core != CW'(q[0].core) || pkt_type != 2'(q[0].kind) || pkt_l1i != q[0].li
              || pkt_l1d != q[0].ld || pkt_idx != IW'(q[0].idx)) begin
            fails++;
            $display("FAIL %s: got core=%0d type=%0d i=%0b d=%0b idx=%0d expected core=%0d type=%0d i=%0b d=%0b idx=%0d",
                     was_stall ? "R11" : q[0].tag, pkt_core, pkt_type, pkt_l1i, pkt_l1d, pkt_idx,
                     q[0].core, q[0].kind, q[0].li, q[0].ld, q[0].idx);
          end
          if (nr) begin
            g = q[0].grp;
            void'(q.pop_front());
            expect_cont = (q.size() > 0) && (q[0].grp == g);
          end
        end
        was_stall = !nr;
      end else begin
        was_stall = 1'b0;
      end
      pkt_ready = nr;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    evict_valid = 1'b0; req_valid = 1'b0; evict_idx = '0; req_idx = '0;
    req_core = '0; req_op = '0; pkt_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: sweep in progress
    @(negedge clk);
    checks++;
    if (in_ready || pkt_valid) begin
      fails++;
      $display("FAIL R1: in_ready=%0b pkt_valid=%0b expected 0/0 during sweep", in_ready, pkt_valid);
    end
    repeat (L + 2) @(negedge clk);
    checks++;
    if (!in_ready) begin
      fails++;
      $display("FAIL R1: in_ready=%0b expected 1 after sweep", in_ready);
    end
    running = 1'b1;

    // R1/R3: empty directory, plain ack only
    issue(0, 0, 1, 1, 2, 3); drain();
    // R2/R4/R5/R8: four holders, store by core 1
    issue(0, 0, 1, 0, 1, 5);
    issue(0, 0, 1, 2, 0, 5);
    issue(0, 0, 1, 3, 1, 5);
    issue(0, 0, 1, 1, 1, 5);
    tag_ovr = "R8";
    issue(0, 0, 1, 1, 2, 5); drain();
    tag_ovr = "R5";
    issue(0, 0, 1, 1, 2, 5); drain();
    tag_ovr = "";
    // R7: eviction to holders, then a store sees an empty slot
    issue(0, 0, 1, 2, 0, 5);
    issue(1, 5, 0, 0, 0, 0); drain();
    issue(0, 0, 1, 0, 2, 5); drain();
    // R6: requester keeps its own instruction copy across its store
    tag_ovr = "R6";
    issue(0, 0, 1, 0, 0, 7);
    issue(0, 0, 1, 0, 2, 7); drain();
    issue(1, 7, 0, 0, 0, 0); drain();
    // R10: eviction and store together, same slot and different slots
    tag_ovr = "R10";
    issue(0, 0, 1, 0, 1, 9);
    issue(0, 0, 1, 3, 1, 9);
    issue(1, 9, 1, 2, 2, 9); drain();
    issue(0, 0, 1, 1, 0, 10);
    issue(0, 0, 1, 2, 1, 12);
    issue(1, 10, 1, 0, 2, 12); drain();
    // R10: fill lands after its own slot's eviction and survives
    issue(1, 11, 1, 1, 1, 11); drain();
    issue(1, 11, 0, 0, 0, 0); drain();
    // R11: random traffic with receiver stalls on a few slots
    tag_ovr = "";
    stall = 1'b1;
    for (int n = 0; n < 400; n++) begin
      bit ev, rq;
      ev = ($urandom % 4) == 0;
      rq = ($urandom % 5) != 0;
      if (!ev && !rq) rq = 1'b1;
      issue(ev, $urandom % 4, rq, $urandom % N, $urandom % 3, $urandom % 4);
    end
    drain();
    stall = 1'b0;
    repeat (4) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R3: %0d packets missing, expected 0", q.size());
    end
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule